// File: doc/BRIEF.md
# Programmable Asynchronous Memory Access Sequencer

This block runs one access at a time on an external parallel memory bus. A request carries direction, address, write data and a word count for reads. The block first looks up which chip-select window holds the address. It then starts a cycle counter and drives the chip-select, address-latch, write-strobe and read-strobe lines. Each line goes low and high again at counter values held in the timing set of the selected chip-select.

Read data is captured when the counter reaches the programmed access time. In a multi-word read, the following words are captured at a programmed spacing, with the address stepping by one word each time. The access ends when the counter reaches the total length programmed for its direction. A request that falls outside every enabled window is accepted, touches no pin and returns an error at once. Timing sets and windows are loaded through a narrow configuration write port.

Top module: `memseq_top`

## Requirements
- R1: After reset every timing field reads as zero, windows 1 to 7 are disabled, window 0 covers base 0x0800_0000 with size 0x1000_0000, every strobe pin is high, `req_ready` is 1 and `rsp_done` is 0.
- R2: When `cfg_wr` is high at a clock edge, `cfg_data` is stored into field `cfg_field` of set `cfg_cs`. Codes: 0 cs on, 1 cs read off, 2 cs write off, 3 adv on, 4 adv read off, 5 adv write off, 6 we on, 7 we off, 8 oe on, 9 oe off, 10 access, 11 word gap, 12 read total, 13 write total, 14 window base, 15 window size. Timing fields keep the low 6 bits.
- R3: Address A hits window i when the size is nonzero and base <= A < base+size. When windows overlap, the lowest index wins.
- R4: A request that hits no window is accepted. In the cycle after the accepting edge, `rsp_done` and `rsp_err` are high for one cycle. No strobe pin moves.
- R5: The counter holds k during the k-th cycle after the accepting edge, counting from 0. `req_ready` stays low from acceptance until the done pulse.
- R6: A strobe is low exactly while on <= count < off. When off <= on, the strobe never goes low.
- R7: Chip-select and address-latch use the read off time on reads and the write off time on writes. Only the pin of the selected chip-select moves.
- R8: The write strobe moves only on writes. The read strobe moves only on reads.
- R9: A read word is captured from `mem_rdata` in the cycle whose count equals the access time. It appears on `rsp_rdata` with a one-cycle `rsp_rvalid` in the next cycle. `rsp_rdata` then holds that value.
- R10: Let T be the total for the direction, with 0 treated as 1. The last busy count is T-1. `rsp_done` is high, with `rsp_err` low, in the cycle that follows.
- R11: A read with `req_len` = L moves L+1 words. Word k is captured at access + k*G on address start+k, where G is the word gap with 0 treated as 1. T grows by L*G. A capture point at or beyond T is skipped.
- R12: Writes ignore `req_len` and move one word. During the access, `mem_wdata` holds the request data and `mem_wdata_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_cs | input | 3 | Chip-select set to write |
| cfg_field | input | 4 | Field code, see R2 |
| cfg_data | input | 32 | Field value |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Start word address |
| req_wdata | input | 16 | Write data |
| req_len | input | 3 | Extra read words |
| rsp_done | output | 1 | Access finished pulse |
| rsp_err | output | 1 | No window hit, valid with done |
| rsp_rvalid | output | 1 | Read word captured pulse |
| rsp_rdata | output | 16 | Last captured read word |
| mem_cs_n | output | 8 | Chip-select pins, active low |
| mem_adv_n | output | 1 | Address latch, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_wdata_en | output | 1 | Write data drive enable |
| mem_rdata | input | 16 | Memory read data |

## Verification
The bench aims at off-by-one edges. These are the zero-default cycle, which must still last one cycle and capture at count 0, a strobe whose off time equals its on time, and the last and first addresses around a window boundary. A design with the wrong comparator sense would show a strobe one cycle long or shifted, or a done pulse one cycle off. It also covers overlapping windows, a zero word gap and an access time past the total. A wrong priority would drive the wrong chip-select pin. A wrong gap rule would capture words twice, or on the wrong address. A capture past the end would return a word that should not exist. A write with a nonzero word count checks that writes do not grow the way burst reads do.

// File: rtl/memseq_pkg.sv
package memseq_pkg;
  localparam int TIME_W = 6;
  localparam int LEN_W  = 3;
  localparam int CNT_W  = TIME_W + LEN_W + 2;

  typedef logic [TIME_W-1:0] tw_t;
  typedef logic [LEN_W-1:0]  len_t;
  typedef logic [LEN_W:0]    widx_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  typedef enum logic [3:0] {
    F_CS_ON, F_CS_RD_OFF, F_CS_WR_OFF, F_ADV_ON, F_ADV_RD_OFF, F_ADV_WR_OFF,
    F_WE_ON, F_WE_OFF, F_OE_ON, F_OE_OFF, F_ACCESS, F_GAP, F_RD_TOTAL,
    F_WR_TOTAL, F_WIN_BASE, F_WIN_SIZE
  } cfg_field_e;

  typedef struct packed {
    tw_t cs_on, cs_rd_off, cs_wr_off;
    tw_t adv_on, adv_rd_off, adv_wr_off;
    tw_t we_on, we_off, oe_on, oe_off;
    tw_t access, gap, rd_total, wr_total;
  } timing_t;

  function automatic logic strobe_active(cnt_t c, tw_t on, tw_t off);
    return (c >= cnt_t'(on)) && (c < cnt_t'(off));
  endfunction

  function automatic cnt_t eff_gap(tw_t g);
    return (g == '0) ? cnt_t'(1) : cnt_t'(g);
  endfunction

  function automatic cnt_t end_count(tw_t total, logic is_wr, tw_t gap, len_t len);
    cnt_t b;
    b = (total == '0) ? cnt_t'(1) : cnt_t'(total);
    if (!is_wr) b = b + cnt_t'(len) * eff_gap(gap);
    return b;
  endfunction

  function automatic cnt_t sample_point(tw_t acc, tw_t gap, widx_t k);
    return cnt_t'(acc) + cnt_t'(k) * eff_gap(gap);
  endfunction
endpackage

// File: rtl/memseq_cfg.sv
module memseq_cfg
  import memseq_pkg::*;
#(
  parameter int NCS = 8,
  parameter int AW = 32,
  parameter logic [AW-1:0] CS0_BASE = 32'h0800_0000,
  parameter logic [AW-1:0] CS0_SIZE = 32'h1000_0000,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic [CSW-1:0] cfg_cs,
  input  logic [3:0]     cfg_field,
  input  logic [AW-1:0]  cfg_data,
  output timing_t        tim_o  [NCS],
  output logic [AW-1:0]  base_o [NCS],
  output logic [AW-1:0]  size_o [NCS]
);
  tw_t val;
  assign val = cfg_data[TIME_W-1:0];

  for (genvar i = 0; i < NCS; i++) begin : g_set
    timing_t       t_q;
    logic [AW-1:0] b_q, s_q;
    logic          sel;
    assign sel = cfg_wr && (cfg_cs == CSW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        t_q <= '0;
        b_q <= (i == 0) ? CS0_BASE : '0;
        s_q <= (i == 0) ? CS0_SIZE : '0;
      end else if (sel) begin
        case (cfg_field_e'(cfg_field))
          F_CS_ON:      t_q.cs_on      <= val;
          F_CS_RD_OFF:  t_q.cs_rd_off  <= val;
          F_CS_WR_OFF:  t_q.cs_wr_off  <= val;
          F_ADV_ON:     t_q.adv_on     <= val;
          F_ADV_RD_OFF: t_q.adv_rd_off <= val;
          F_ADV_WR_OFF: t_q.adv_wr_off <= val;
          F_WE_ON:      t_q.we_on      <= val;
          F_WE_OFF:     t_q.we_off     <= val;
          F_OE_ON:      t_q.oe_on      <= val;
          F_OE_OFF:     t_q.oe_off     <= val;
          F_ACCESS:     t_q.access     <= val;
          F_GAP:        t_q.gap        <= val;
          F_RD_TOTAL:   t_q.rd_total   <= val;
          F_WR_TOTAL:   t_q.wr_total   <= val;
          F_WIN_BASE:   b_q            <= cfg_data;
          default:      s_q            <= cfg_data;
        endcase
      end
    end

    assign tim_o[i]  = t_q;
    assign base_o[i] = b_q;
    assign size_o[i] = s_q;
  end
endmodule

// File: rtl/memseq_decode.sv
module memseq_decode #(
  parameter int NCS = 8,
  parameter int AW = 32,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic [AW-1:0]  addr,
  input  logic [AW-1:0]  base_i [NCS],
  input  logic [AW-1:0]  size_i [NCS],
  output logic           hit,
  output logic [CSW-1:0] hit_cs
);
  function automatic logic in_range(logic [AW-1:0] a, logic [AW-1:0] b, logic [AW-1:0] s);
    logic [AW:0] lo, hi, ax;
    ax = {1'b0, a};
    lo = {1'b0, b};
    hi = lo + {1'b0, s};
    return (s != '0) && (ax >= lo) && (ax < hi);
  endfunction

  // lowest index wins (R3): scan downward so the last match kept is the lowest
  always_comb begin
    hit    = 1'b0;
    hit_cs = '0;
    for (int i = NCS - 1; i >= 0; i--) begin
      if (in_range(addr, base_i[i], size_i[i])) begin
        hit    = 1'b1;
        hit_cs = CSW'(i);
      end
    end
  end
endmodule

// File: rtl/memseq_core.sv
module memseq_core
  import memseq_pkg::*;
#(
  parameter int NCS = 8,
  parameter int AW = 32,
  parameter int DW = 16,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  timing_t        tim_i [NCS],
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  len_t           req_len,
  input  logic           hit,
  input  logic [CSW-1:0] hit_cs,
  output logic           rsp_done,
  output logic           rsp_err,
  output logic           rsp_rvalid,
  output logic [DW-1:0]  rsp_rdata,
  output logic [NCS-1:0] mem_cs_n,
  output logic           mem_adv_n,
  output logic           mem_we_n,
  output logic           mem_oe_n,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic           mem_wdata_en,
  input  logic [DW-1:0]  mem_rdata
);
  logic           busy_q, wr_q, done_q, err_q, rvalid_q;
  cnt_t           cnt_q;
  logic [CSW-1:0] cs_q;
  len_t           len_q;
  widx_t          widx_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q, rdata_q;

  timing_t t_sel;
  cnt_t    end_cnt;
  logic    accept, smp_ev, end_ev, cs_act, adv_act;

  assign t_sel   = tim_i[cs_q];
  assign accept  = req_valid && !busy_q;
  assign end_cnt = end_count(wr_q ? t_sel.wr_total : t_sel.rd_total, wr_q, t_sel.gap, len_q);
  assign end_ev  = busy_q && ((cnt_q + cnt_t'(1)) == end_cnt);
  assign smp_ev  = busy_q && !wr_q && (widx_q <= {1'b0, len_q}) &&
                   (cnt_q == sample_point(t_sel.access, t_sel.gap, widx_q)) &&
                   (cnt_q < end_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; wr_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0; rvalid_q <= 1'b0;
      cnt_q <= '0; cs_q <= '0; len_q <= '0; widx_q <= '0;
      addr_q <= '0; wdata_q <= '0; rdata_q <= '0;
    end else begin
      done_q   <= 1'b0;
      rvalid_q <= 1'b0;
      if (accept) begin
        if (hit) begin
          busy_q  <= 1'b1;
          cnt_q   <= '0;
          wr_q    <= req_write;
          cs_q    <= hit_cs;
          len_q   <= req_len;
          widx_q  <= '0;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
        end else begin
          done_q <= 1'b1;
          err_q  <= 1'b1;
        end
      end else if (busy_q) begin
        cnt_q <= cnt_q + cnt_t'(1);
        if (smp_ev) begin
          rdata_q  <= mem_rdata;
          rvalid_q <= 1'b1;
          widx_q   <= widx_q + widx_t'(1);
        end
        if (end_ev) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          err_q  <= 1'b0;
        end
      end
    end
  end

  assign cs_act  = busy_q && strobe_active(cnt_q, t_sel.cs_on,
                                           wr_q ? t_sel.cs_wr_off : t_sel.cs_rd_off);
  assign adv_act = busy_q && strobe_active(cnt_q, t_sel.adv_on,
                                           wr_q ? t_sel.adv_wr_off : t_sel.adv_rd_off);

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign mem_cs_n[i] = !(cs_act && (cs_q == CSW'(i)));
  end

  assign mem_adv_n    = !adv_act;
  assign mem_we_n     = !(busy_q && wr_q && strobe_active(cnt_q, t_sel.we_on, t_sel.we_off));
  assign mem_oe_n     = !(busy_q && !wr_q && strobe_active(cnt_q, t_sel.oe_on, t_sel.oe_off));
  assign mem_addr     = addr_q + AW'(widx_q);
  assign mem_wdata    = wdata_q;
  assign mem_wdata_en = busy_q && wr_q;
  assign req_ready    = !busy_q;
  assign rsp_done     = done_q;
  assign rsp_err      = done_q && err_q;
  assign rsp_rvalid   = rvalid_q;
  assign rsp_rdata    = rdata_q;

  // R5: counter advances by one every busy cycle until the end
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !end_ev) |=> (busy_q && (cnt_q == cnt_t'($past(cnt_q) + cnt_t'(1)))));
  // R4: a miss reports an error at once and starts no access
  a_r4_miss_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |=> (rsp_done && rsp_err && !busy_q));
  // R10: the end of the count yields a clean done and frees the port
  a_r10_end_done: assert property (@(posedge clk) disable iff (!rst_n)
    end_ev |=> (rsp_done && !rsp_err && req_ready));
  // R9: each capture is announced in the following cycle
  a_r9_capture_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ev |=> rsp_rvalid);
  // R6: all strobe pins rest high while no access runs
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> ((&mem_cs_n) && mem_adv_n && mem_we_n && mem_oe_n));
  // R8: write and read strobes never low together
  a_r8_we_oe_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));
endmodule

// File: rtl/memseq_top.sv
module memseq_top
  import memseq_pkg::*;
#(
  parameter int NCS = 8,
  parameter int AW = 32,
  parameter int DW = 16,
  parameter logic [AW-1:0] CS0_BASE = 32'h0800_0000,
  parameter logic [AW-1:0] CS0_SIZE = 32'h1000_0000,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CSW-1:0]   cfg_cs,
  input  logic [3:0]       cfg_field,
  input  logic [AW-1:0]    cfg_data,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [LEN_W-1:0] req_len,
  output logic             rsp_done,
  output logic             rsp_err,
  output logic             rsp_rvalid,
  output logic [DW-1:0]    rsp_rdata,
  output logic [NCS-1:0]   mem_cs_n,
  output logic             mem_adv_n,
  output logic             mem_we_n,
  output logic             mem_oe_n,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             mem_wdata_en,
  input  logic [DW-1:0]    mem_rdata
);
  timing_t        tim   [NCS];
  logic [AW-1:0]  wbase [NCS];
  logic [AW-1:0]  wsize [NCS];
  logic           hit;
  logic [CSW-1:0] hit_cs;

  memseq_cfg #(.NCS(NCS), .AW(AW), .CS0_BASE(CS0_BASE), .CS0_SIZE(CS0_SIZE)) i_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_cs(cfg_cs), .cfg_field(cfg_field),
    .cfg_data(cfg_data), .tim_o(tim), .base_o(wbase), .size_o(wsize)
  );

  memseq_decode #(.NCS(NCS), .AW(AW)) i_decode (
    .addr(req_addr), .base_i(wbase), .size_i(wsize), .hit(hit), .hit_cs(hit_cs)
  );

  memseq_core #(.NCS(NCS), .AW(AW), .DW(DW)) i_core (
    .clk(clk), .rst_n(rst_n), .tim_i(tim), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_len(req_len),
    .hit(hit), .hit_cs(hit_cs), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .rsp_rvalid(rsp_rvalid), .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n),
    .mem_adv_n(mem_adv_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wdata_en(mem_wdata_en), .mem_rdata(mem_rdata)
  );

  // R7: at most one chip-select pin low at any time
  a_r7_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));
endmodule

// File: tb/test_memseq_top.sv
module test_memseq_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_cs = '0;
  logic [3:0]  cfg_field = '0;
  logic [31:0] cfg_data = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [2:0]  req_len = '0;
  logic        req_ready, rsp_done, rsp_err, rsp_rvalid, mem_adv_n, mem_we_n, mem_oe_n, mem_wdata_en;
  logic [15:0] rsp_rdata, mem_wdata, mem_rdata;
  logic [7:0]  mem_cs_n;
  logic [31:0] mem_addr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [15:0] mem_word(logic [31:0] a);
    return {a[7:0], ~a[7:0]};
  endfunction
  assign mem_rdata = mem_word(mem_addr);

  memseq_top i_memseq_top (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_cs(cfg_cs), .cfg_field(cfg_field),
    .cfg_data(cfg_data), .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_len(req_len), .rsp_done(rsp_done),
    .rsp_err(rsp_err), .rsp_rvalid(rsp_rvalid), .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n),
    .mem_adv_n(mem_adv_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wdata_en(mem_wdata_en), .mem_rdata(mem_rdata)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  // bench-side mirror of the configuration
  int tcfg [8][14];
  longint wbase [8];
  longint wsize [8];
  logic [15:0] last_rd = '0;

  typedef struct {
    int c0; bit err; int lat; logic [15:0] last; logic [15:0] wd; bit wr;
    int line; logic [63:0] cs_m, adv_m, we_m, oe_m; string tag;
  } exp_t;
  exp_t eq[$];
  logic [15:0] wq[$];

  function automatic logic [63:0] win_mask(int on, int off, int t);
    logic [63:0] m = '0;
    for (int j = 0; j < 64; j++) if (j >= on && j < off && j < t) m[j] = 1'b1;
    return m;
  endfunction

  task automatic cfg(int cs, int f, longint v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_cs = 3'(cs); cfg_field = 4'(f); cfg_data = 32'(v);
    @(negedge clk);
    cfg_wr = 1'b0;
    if (f < 14) tcfg[cs][f] = int'(v & 63);
    else if (f == 14) wbase[cs] = v;
    else wsize[cs] = v;
  endtask

  task automatic access(bit wr, logic [31:0] addr, int len, logic [15:0] wd, string tag);
    exp_t e;
    int line = -1;
    for (int i = 7; i >= 0; i--)
      if (wsize[i] != 0 && longint'(addr) >= wbase[i] && longint'(addr) < wbase[i] + wsize[i]) line = i;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_len = 3'(len); req_wdata = wd;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    e.c0 = cyc; e.tag = tag; e.wr = wr; e.wd = wd; e.line = line;
    e.cs_m = '0; e.adv_m = '0; e.we_m = '0; e.oe_m = '0;
    if (line < 0) begin
      e.err = 1'b1; e.lat = 0;
    end else begin
      int g, t;
      g = (tcfg[line][11] == 0) ? 1 : tcfg[line][11];
      if (wr) t = (tcfg[line][13] == 0) ? 1 : tcfg[line][13];
      else t = ((tcfg[line][12] == 0) ? 1 : tcfg[line][12]) + len * g;
      e.err = 1'b0; e.lat = t;
      e.cs_m  = win_mask(tcfg[line][0], tcfg[line][wr ? 2 : 1], t);
      e.adv_m = win_mask(tcfg[line][3], tcfg[line][wr ? 5 : 4], t);
      if (wr) e.we_m = win_mask(tcfg[line][6], tcfg[line][7], t);
      else begin
        e.oe_m = win_mask(tcfg[line][8], tcfg[line][9], t);
        for (int k = 0; k <= len; k++)
          if (tcfg[line][10] + k * g < t) begin
            wq.push_back(mem_word(addr + 32'(k)));
            last_rd = mem_word(addr + 32'(k));
          end
      end
    end
    e.last = last_rd;
    eq.push_back(e);
    while (eq.size() != 0) @(negedge clk);
  endtask

  // monitor: observes pins and responses, compares with scoreboard entries
  logic [63:0] o_cs = '0, o_adv = '0, o_we = '0, o_oe = '0;
  bit o_other = 0, o_wdbad = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (eq.size() != 0) begin
        int j;
        j = cyc - eq[0].c0;
        for (int i = 0; i < 8; i++) if (!mem_cs_n[i] && i != eq[0].line) o_other = 1;
        if (j >= 0 && j < 64) begin
          if (eq[0].line >= 0 && !mem_cs_n[eq[0].line]) o_cs[j] = 1'b1;
          if (!mem_adv_n) o_adv[j] = 1'b1;
          if (!mem_we_n) o_we[j] = 1'b1;
          if (!mem_oe_n) o_oe[j] = 1'b1;
        end
        if (eq[0].wr && eq[0].line >= 0 && j < eq[0].lat && (!mem_wdata_en || mem_wdata !== eq[0].wd))
          o_wdbad = 1;
      end
      if (rsp_rvalid) begin
        if (wq.size() == 0) check(0, "R9 R11", "unexpected read word", rsp_rdata, 0);
        else begin
          logic [15:0] w;
          w = wq.pop_front();
          check(rsp_rdata === w, "R9 R11", "read word", rsp_rdata, w);
        end
      end
      if (rsp_done) begin
        if (eq.size() == 0) check(0, "R5 R10", "unexpected done", 1, 0);
        else begin
          exp_t e;
          int j;
          e = eq.pop_front();
          j = cyc - e.c0;
          check(rsp_err === e.err, e.err ? "R4" : "R10", {e.tag, " error flag"}, rsp_err, e.err);
          check(j == e.lat, "R2 R5 R10 R11 R12", {e.tag, " done latency"}, j, e.lat);
          check(rsp_rdata === e.last, "R9", {e.tag, " held read data"}, rsp_rdata, e.last);
          check(o_cs == e.cs_m, "R6 R7", {e.tag, " cs window"}, o_cs, e.cs_m);
          check(!o_other, "R3 R7", {e.tag, " foreign cs pin"}, o_other, 0);
          check(o_adv == e.adv_m, "R6 R7", {e.tag, " adv window"}, o_adv, e.adv_m);
          check(o_we == e.we_m, "R6 R8", {e.tag, " we window"}, o_we, e.we_m);
          check(o_oe == e.oe_m, "R6 R8", {e.tag, " oe window"}, o_oe, e.oe_m);
          check(wq.size() == 0, "R11", {e.tag, " missing read words"}, wq.size(), 0);
          check(!o_wdbad, "R12", {e.tag, " write data drive"}, o_wdbad, 0);
          wq.delete();
        end
        o_cs = '0; o_adv = '0; o_we = '0; o_oe = '0; o_other = 0; o_wdbad = 0;
      end
    end
  end

  task automatic summary;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    foreach (tcfg[i, f]) tcfg[i][f] = 0;
    foreach (wbase[i]) begin wbase[i] = 0; wsize[i] = 0; end
    wbase[0] = 64'h0800_0000; wsize[0] = 64'h1000_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(req_ready === 1'b1, "R1", "ready after reset", req_ready, 1);
    check(mem_cs_n === 8'hFF, "R1", "cs pins after reset", mem_cs_n, 8'hFF);
    check({mem_adv_n, mem_we_n, mem_oe_n} === 3'b111, "R1", "strobes after reset",
          {mem_adv_n, mem_we_n, mem_oe_n}, 3'b111);
    check(rsp_done === 1'b0, "R1", "done after reset", rsp_done, 0);

    // R1 R10: zero timing gives a one-cycle access capturing at count 0
    access(0, 32'h0800_0000, 0, '0, "R1 zero read");

    // R2: load chip-select 0 timing
    cfg(0, 0, 1);  cfg(0, 1, 9);  cfg(0, 2, 7);
    cfg(0, 3, 0);  cfg(0, 4, 2);  cfg(0, 5, 3);
    cfg(0, 6, 2);  cfg(0, 7, 6);  cfg(0, 8, 3);  cfg(0, 9, 8);
    cfg(0, 10, 6); cfg(0, 11, 2); cfg(0, 12, 10); cfg(0, 13, 8);

    access(0, 32'h0800_1230, 0, '0, "R9 single read");
    access(1, 32'h0800_0044, 2, 16'hBEEF, "R12 write ignores len");
    access(0, 32'h0800_00FE, 3, '0, "R11 burst read");
    access(0, 32'h0000_0100, 0, '0, "R4 miss");
    access(0, 32'h17FF_FFFF, 0, '0, "R3 last window word");
    access(1, 32'h1800_0000, 0, 16'h1234, "R3 R4 past window");

    // R6: off equal to on keeps the write strobe high
    cfg(0, 7, 2);
    access(1, 32'h0800_0010, 0, 16'h5555, "R6 we off equals on");

    // R11: capture point past the end is skipped
    cfg(0, 10, 12);
    access(0, 32'h0800_0020, 1, '0, "R11 access past total");

    // R3: overlapping window 2 loses to window 0; window 3 used alone
    cfg(2, 14, 64'h1000_0000); cfg(2, 15, 64'h100);
    cfg(3, 14, 64'h2000_0000); cfg(3, 15, 64'h1000);
    cfg(3, 0, 0); cfg(3, 1, 4); cfg(3, 8, 1); cfg(3, 9, 3);
    cfg(3, 10, 1); cfg(3, 12, 5);
    access(0, 32'h1000_0010, 0, '0, "R3 overlap priority");
    access(0, 32'h2000_0FFF, 0, '0, "R3 R7 window 3 edge");
    access(0, 32'h2000_0010, 2, '0, "R11 zero gap burst");
    access(0, 32'h2000_1000, 0, '0, "R3 R4 window 3 end");

    repeat (3) @(negedge clk);
    summary();
  end
endmodule